// File: doc/BRIEF.md
# Selective Speculation Controller

This controller sits beside a core's retirement stage and decides when to start, commit and abort post-retirement speculation. It watches which kind of instruction is waiting to retire and whether the store buffer still holds stores. From these and the selected consistency model it decides whether retirement would otherwise stall on an ordering rule. When it would, the controller takes a register checkpoint and lets retirement run ahead. It commits in one cycle, with a single flash clear, as soon as the store buffer is empty and no atomic read-modify-write is split across the boundary.

When the violation tracker reports a conflicting external request, the default is to abort at once. The abort invalidates the speculative store-buffer entries, conditionally invalidates written cache blocks, clears the tracking bits, flushes the pipeline and restores the checkpoint. In commit-on-violate mode the controller instead holds the offending snoop for a bounded number of cycles. If the store buffer drains within that window it commits, which releases the snoop. Otherwise it aborts. An eviction of a speculatively accessed block, or an instruction with irreversible side effects, forces a commit. Retirement is held until the store buffer drains.

Top module: `spec_order_ctrl`

## Requirements
- R1: With `mode_i` = 0 (sequentially consistent), speculation starts when `rdy_load_i` is high and `sb_empty_i` is low. Other ready signals start nothing in this mode.
- R2: With `mode_i` = 1 (store-to-load relaxed), speculation starts when `rdy_store_i` or `rdy_atomic_i` is high and `sb_empty_i` is low.
- R3: With `mode_i` = 2 (fully relaxed), speculation starts when `rdy_fence_i` is high with `sb_empty_i` low, or when `rdy_atomic_i` and `atomic_miss_i` are both high. `mode_i` = 3 never starts speculation.
- R4: A start raises `ckpt_take_o` for exactly one cycle, in the cycle after the start condition is sampled, and `spec_active_o` rises in that same cycle. While speculating, ready fences and loads take no further checkpoint and `hold_retire_o` stays low.
- R5: While speculating, a sampled `sb_empty_i` high (with `rmw_pending_i` low) gives a one-cycle `flash_commit_o` in the next cycle, and `spec_active_o` goes low in that cycle.
- R6: `irrev_i` or `evict_spec_i` during speculation with a non-empty store buffer raises `hold_retire_o` from the next cycle. No commit happens until `sb_empty_i` is seen high, and then the commit pulse follows and the hold drops.
- R7: No commit happens while `rmw_pending_i` is high, even with an empty store buffer.
- R8: With `cov_en_i` low, a violation during speculation gives one cycle in which `flash_abort_o`, `flush_o` and `ckpt_restore_o` are all high, in the cycle after the violation is sampled. All three are low in the cycle after that.
- R9: With `cov_en_i` high, a violation raises `snoop_hold_o` in the next cycle instead of aborting. If the store buffer then drains, `flash_commit_o` pulses and `snoop_hold_o` drops in the same cycle.
- R10: If the store buffer does not drain, `snoop_hold_o` stays high for exactly `COV_CYCLES` cycles. In the following cycle it is low and the abort pulses of R8 appear. The window restarts from zero on every entry.
- R11: After an abort, no speculation starts until `retire_i` has been sampled high while not speculating. The start can come at the earliest one cycle after that retirement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Consistency model: 0 SC, 1 store-to-load relaxed, 2 fully relaxed, 3 reserved |
| cov_en_i | input | 1 | Commit-on-violate policy enable |
| rdy_load_i | input | 1 | Load at retirement head, ready |
| rdy_store_i | input | 1 | Store at retirement head, ready |
| rdy_atomic_i | input | 1 | Atomic at retirement head, ready |
| rdy_fence_i | input | 1 | Fence at retirement head, ready |
| atomic_miss_i | input | 1 | Head atomic would stall on a store miss to its block |
| sb_empty_i | input | 1 | Store buffer holds no stores |
| rmw_pending_i | input | 1 | An atomic has retired its read half but not its write half |
| retire_i | input | 1 | An instruction retired this cycle |
| violation_i | input | 1 | Tracker reports a conflicting external request |
| evict_spec_i | input | 1 | Cache wants to evict a speculatively accessed block |
| irrev_i | input | 1 | Head instruction has irreversible side effects |
| ckpt_take_o | output | 1 | Take register checkpoint (pulse) |
| ckpt_restore_o | output | 1 | Restore register checkpoint (pulse) |
| flash_commit_o | output | 1 | Flash clear of speculative read/write bits (pulse) |
| flash_abort_o | output | 1 | Invalidate speculative entries, conditional invalidate, clear bits (pulse) |
| flush_o | output | 1 | Flush in-flight instructions (pulse) |
| snoop_hold_o | output | 1 | Defer the offending external request |
| hold_retire_o | output | 1 | Stop retirement (forced commit drain or abort) |
| spec_active_o | output | 1 | Speculation in progress |

## Verification
The start decision is swept over every combination of mode, the four ready signals, store-buffer occupancy and the atomic-miss flag. This shows that each model reacts only to its own instruction class and that no start happens with an empty buffer, except for the atomic-miss case. Directed sequences then separate opportunistic commit from forced commit and from a commit blocked by a split atomic. Each is judged by when the commit pulse and the retirement hold appear. Violation handling is driven once with each policy. With commit-on-violate, one run lets the buffer drain inside the window and one does not. The second run follows a partly used window, so its exact hold length shows that the timer restarts on entry. A blocked restart after an abort, released by a single retirement, closes the set.

// File: rtl/spec_ctrl_pkg.sv
package spec_ctrl_pkg;

  typedef enum logic [1:0] {
    MODE_SC   = 2'd0,
    MODE_TSO  = 2'd1,
    MODE_RMO  = 2'd2,
    MODE_RSVD = 2'd3
  } cons_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SPEC  = 3'd1,
    ST_DRAIN = 3'd2,
    ST_COV   = 3'd3,
    ST_ABORT = 3'd4
  } spec_state_e;

endpackage

// File: rtl/spec_start_decode.sv
module spec_start_decode
  import spec_ctrl_pkg::*;
(
  input  logic [1:0] mode_i,
  input  logic       rdy_load_i,
  input  logic       rdy_store_i,
  input  logic       rdy_atomic_i,
  input  logic       rdy_fence_i,
  input  logic       atomic_miss_i,
  input  logic       sb_empty_i,
  output logic       start_o
);

  cons_mode_e mode;
  logic       sb_busy;

  assign mode    = cons_mode_e'(mode_i);
  assign sb_busy = ~sb_empty_i;

  always_comb begin
    case (mode)
      MODE_SC:  start_o = rdy_load_i & sb_busy;
      MODE_TSO: start_o = (rdy_store_i | rdy_atomic_i) & sb_busy;
      MODE_RMO: start_o = (rdy_fence_i & sb_busy) | (rdy_atomic_i & atomic_miss_i);
      default:  start_o = 1'b0;
    endcase
  end

  always_comb begin
    if (start_o) begin
      AST_START_HAS_CAUSE: assert (sb_busy || (rdy_atomic_i && atomic_miss_i)); // R3
    end
  end

endmodule

// File: rtl/spec_cov_timer.sv
module spec_cov_timer #(
  parameter int COV_CYCLES = 4000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic run_i,
  output logic expired_o
);

  localparam int CW = $clog2(COV_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(COV_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  assign expired_o = run_i && (cnt_q == LAST);
  assign cnt_en    = clr_i | (run_i & ~expired_o);

  always_comb begin
    if (clr_i) cnt_d = '0;
    else       cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  AST_CNT_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST); // R10

  AST_CLR_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0)); // R10

endmodule

// File: rtl/spec_ctrl_fsm.sv
module spec_ctrl_fsm
  import spec_ctrl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic cov_mode_i,
  input  logic violation_i,
  input  logic force_i,
  input  logic sb_empty_i,
  input  logic rmw_pending_i,
  input  logic retire_i,
  input  logic timeout_i,
  output logic cov_clr_o,
  output logic cov_run_o,
  output logic take_o,
  output logic commit_o,
  output logic abort_o,
  output logic snoop_hold_o,
  output logic hold_retire_o,
  output logic active_o
);

  spec_state_e st_q, st_d;
  logic        take_q, take_d;
  logic        commit_q, commit_d;
  logic        need_ret_q, need_ret_d, need_ret_en;
  logic        can_commit;

  assign can_commit = sb_empty_i & ~rmw_pending_i;

  always_comb begin
    st_d      = st_q;
    take_d    = 1'b0;
    commit_d  = 1'b0;
    cov_clr_o = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start_i && !need_ret_q) begin
          st_d   = ST_SPEC;
          take_d = 1'b1;
        end
      end
      ST_SPEC, ST_DRAIN: begin
        if (violation_i) begin
          if (cov_mode_i) begin
            st_d      = ST_COV;
            cov_clr_o = 1'b1;
          end else begin
            st_d = ST_ABORT;
          end
        end else if (can_commit) begin
          st_d     = ST_IDLE;
          commit_d = 1'b1;
        end else if (force_i) begin
          st_d = ST_DRAIN;
        end
      end
      ST_COV: begin
        if (can_commit) begin
          st_d     = ST_IDLE;
          commit_d = 1'b1;
        end else if (timeout_i) begin
          st_d = ST_ABORT;
        end
      end
      ST_ABORT: st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    need_ret_en = (st_q == ST_ABORT) | ((st_q == ST_IDLE) & retire_i);
    need_ret_d  = (st_q == ST_ABORT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      take_q   <= 1'b0;
      commit_q <= 1'b0;
    end else begin
      st_q     <= st_d;
      take_q   <= take_d;
      commit_q <= commit_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           need_ret_q <= 1'b0;
    else if (need_ret_en) need_ret_q <= need_ret_d;
  end

  assign cov_run_o     = (st_q == ST_COV);
  assign take_o        = take_q;
  assign commit_o      = commit_q;
  assign abort_o       = (st_q == ST_ABORT);
  assign snoop_hold_o  = (st_q == ST_COV);
  assign hold_retire_o = (st_q == ST_DRAIN) | (st_q == ST_ABORT);
  assign active_o      = (st_q == ST_SPEC) | (st_q == ST_DRAIN) | (st_q == ST_COV);

  AST_COMMIT_NEEDS_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    commit_q |-> ($past(sb_empty_i) && !$past(rmw_pending_i))); // R7

  AST_ABORT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ABORT) |=> (st_q == ST_IDLE)); // R8

  AST_NO_START_UNRETIRED: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_IDLE) && need_ret_q) |=> !take_q); // R11

  AST_FORCED_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_DRAIN) && !violation_i && !can_commit) |=> (st_q == ST_DRAIN)); // R6

endmodule

// File: rtl/spec_order_ctrl.sv
module spec_order_ctrl
  import spec_ctrl_pkg::*;
#(
  parameter int COV_CYCLES = 4000,
  parameter bit ENABLE_COV = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_i,
  input  logic       cov_en_i,
  input  logic       rdy_load_i,
  input  logic       rdy_store_i,
  input  logic       rdy_atomic_i,
  input  logic       rdy_fence_i,
  input  logic       atomic_miss_i,
  input  logic       sb_empty_i,
  input  logic       rmw_pending_i,
  input  logic       retire_i,
  input  logic       violation_i,
  input  logic       evict_spec_i,
  input  logic       irrev_i,
  output logic       ckpt_take_o,
  output logic       ckpt_restore_o,
  output logic       flash_commit_o,
  output logic       flash_abort_o,
  output logic       flush_o,
  output logic       snoop_hold_o,
  output logic       hold_retire_o,
  output logic       spec_active_o
);

  logic start;
  logic cov_mode;
  logic cov_clr;
  logic cov_run;
  logic timeout;
  logic abort;

  spec_start_decode u_decode (
    .mode_i        (mode_i),
    .rdy_load_i    (rdy_load_i),
    .rdy_store_i   (rdy_store_i),
    .rdy_atomic_i  (rdy_atomic_i),
    .rdy_fence_i   (rdy_fence_i),
    .atomic_miss_i (atomic_miss_i),
    .sb_empty_i    (sb_empty_i),
    .start_o       (start)
  );

  generate
    if (ENABLE_COV) begin : g_cov
      assign cov_mode = cov_en_i;
      spec_cov_timer #(.COV_CYCLES(COV_CYCLES)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (cov_clr),
        .run_i     (cov_run),
        .expired_o (timeout)
      );
    end else begin : g_no_cov
      assign cov_mode = 1'b0;
      assign timeout  = 1'b0;
    end
  endgenerate

  spec_ctrl_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start),
    .cov_mode_i    (cov_mode),
    .violation_i   (violation_i),
    .force_i       (evict_spec_i | irrev_i),
    .sb_empty_i    (sb_empty_i),
    .rmw_pending_i (rmw_pending_i),
    .retire_i      (retire_i),
    .timeout_i     (timeout),
    .cov_clr_o     (cov_clr),
    .cov_run_o     (cov_run),
    .take_o        (ckpt_take_o),
    .commit_o      (flash_commit_o),
    .abort_o       (abort),
    .snoop_hold_o  (snoop_hold_o),
    .hold_retire_o (hold_retire_o),
    .active_o      (spec_active_o)
  );

  assign flash_abort_o  = abort;
  assign flush_o        = abort;
  assign ckpt_restore_o = abort;

  AST_ONE_FLASH_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ckpt_take_o, flash_commit_o, flash_abort_o})); // R4

  AST_TAKE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ckpt_take_o |=> !ckpt_take_o); // R4

  AST_HOLD_ENDS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(snoop_hold_o) |-> (flash_commit_o || flash_abort_o)); // R9

endmodule

// File: tb/spec_order_ctrl_test.sv
`timescale 1ns/1ps
module spec_order_ctrl_test;

  localparam int WIN = 16;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] mode_i;
  logic       cov_en_i, rdy_load_i, rdy_store_i, rdy_atomic_i, rdy_fence_i;
  logic       atomic_miss_i, sb_empty_i, rmw_pending_i, retire_i;
  logic       violation_i, evict_spec_i, irrev_i;
  logic       ckpt_take_o, ckpt_restore_o, flash_commit_o, flash_abort_o;
  logic       flush_o, snoop_hold_o, hold_retire_o, spec_active_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  spec_order_ctrl #(.COV_CYCLES(WIN), .ENABLE_COV(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .cov_en_i(cov_en_i),
    .rdy_load_i(rdy_load_i), .rdy_store_i(rdy_store_i),
    .rdy_atomic_i(rdy_atomic_i), .rdy_fence_i(rdy_fence_i),
    .atomic_miss_i(atomic_miss_i), .sb_empty_i(sb_empty_i),
    .rmw_pending_i(rmw_pending_i), .retire_i(retire_i),
    .violation_i(violation_i), .evict_spec_i(evict_spec_i), .irrev_i(irrev_i),
    .ckpt_take_o(ckpt_take_o), .ckpt_restore_o(ckpt_restore_o),
    .flash_commit_o(flash_commit_o), .flash_abort_o(flash_abort_o),
    .flush_o(flush_o), .snoop_hold_o(snoop_hold_o),
    .hold_retire_o(hold_retire_o), .spec_active_o(spec_active_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic nb();
    @(negedge clk);
  endtask

  task automatic quiet();
    rdy_load_i = 0; rdy_store_i = 0; rdy_atomic_i = 0; rdy_fence_i = 0;
    atomic_miss_i = 0; sb_empty_i = 1; rmw_pending_i = 0; retire_i = 0;
    violation_i = 0; evict_spec_i = 0; irrev_i = 0;
  endtask

  task automatic start_spec();
    mode_i = 2'd0; rdy_load_i = 1; sb_empty_i = 0;
    nb();
    rdy_load_i = 0;
    chk("R4", "ckpt_take on start", int'(ckpt_take_o), 1);
  endtask

  initial begin
    int n;
    rst_n = 0; mode_i = 0; cov_en_i = 0;
    quiet();
    nb(); nb();
    chk("R4", "reset ckpt_take", int'(ckpt_take_o), 0);
    chk("R5", "reset commit", int'(flash_commit_o), 0);
    chk("R8", "reset abort", int'(flash_abort_o), 0);
    chk("R9", "reset snoop_hold", int'(snoop_hold_o), 0);
    chk("R6", "reset hold_retire", int'(hold_retire_o), 0);
    rst_n = 1;
    nb();

    // R1 R2 R3 sweep of the start decision, each start then committed (R5)
    for (int m = 0; m < 4; m++) begin
      for (int v = 0; v < 64; v++) begin
        bit ld, st, at, fe, se, am, exp;
        string req;
        ld = v[0]; st = v[1]; at = v[2]; fe = v[3]; se = v[4]; am = v[5];
        case (m)
          0: begin exp = ld & !se;               req = "R1"; end
          1: begin exp = (st | at) & !se;        req = "R2"; end
          2: begin exp = (fe & !se) | (at & am); req = "R3"; end
          default: begin exp = 0;                req = "R3"; end
        endcase
        mode_i = 2'(m);
        rdy_load_i = ld; rdy_store_i = st; rdy_atomic_i = at; rdy_fence_i = fe;
        sb_empty_i = se; atomic_miss_i = am;
        nb();
        chk(req, "start decision", int'(ckpt_take_o), int'(exp));
        quiet();
        nb();
        chk("R5", "commit after start", int'(flash_commit_o), int'(exp));
        nb();
      end
    end

    // R4: no re-checkpoint, no hold while speculating with fence/load ready
    start_spec();
    chk("R4", "spec_active on start", int'(spec_active_o), 1);
    rdy_fence_i = 1; rdy_load_i = 1;
    for (int i = 0; i < 2; i++) begin
      nb();
      chk("R4", "no second checkpoint", int'(ckpt_take_o), 0);
      chk("R4", "fence not held", int'(hold_retire_o), 0);
      chk("R4", "still active", int'(spec_active_o), 1);
    end
    quiet();
    nb();
    chk("R5", "commit pulse", int'(flash_commit_o), 1);
    chk("R5", "inactive after commit", int'(spec_active_o), 0);
    nb();
    chk("R5", "commit single pulse", int'(flash_commit_o), 0);

    // R6: forced commit by irreversible op, then by eviction
    for (int k = 0; k < 2; k++) begin
      start_spec();
      if (k == 0) irrev_i = 1; else evict_spec_i = 1;
      nb();
      irrev_i = 0; evict_spec_i = 0;
      for (int i = 0; i < 3; i++) begin
        chk("R6", "retire held", int'(hold_retire_o), 1);
        chk("R6", "no early commit", int'(flash_commit_o), 0);
        nb();
      end
      sb_empty_i = 1;
      nb();
      chk("R6", "forced commit", int'(flash_commit_o), 1);
      chk("R6", "hold released", int'(hold_retire_o), 0);
      quiet();
      nb();
    end

    // R7: split atomic blocks commit
    start_spec();
    rmw_pending_i = 1; sb_empty_i = 1;
    for (int i = 0; i < 3; i++) begin
      nb();
      chk("R7", "no commit mid atomic", int'(flash_commit_o), 0);
      chk("R7", "still active", int'(spec_active_o), 1);
    end
    rmw_pending_i = 0;
    nb();
    chk("R7", "commit after atomic", int'(flash_commit_o), 1);
    quiet();
    nb();

    // R8: abort-immediately policy
    cov_en_i = 0;
    start_spec();
    violation_i = 1;
    nb();
    violation_i = 0;
    chk("R8", "flash_abort", int'(flash_abort_o), 1);
    chk("R8", "flush", int'(flush_o), 1);
    chk("R8", "restore", int'(ckpt_restore_o), 1);
    chk("R8", "no snoop hold", int'(snoop_hold_o), 0);
    nb();
    chk("R8", "abort ends", int'(flash_abort_o | flush_o | ckpt_restore_o), 0);
    chk("R8", "inactive", int'(spec_active_o), 0);

    // R11: blocked restart until one retirement
    mode_i = 0; rdy_load_i = 1; sb_empty_i = 0;
    for (int i = 0; i < 3; i++) begin
      nb();
      chk("R11", "no start before retire", int'(ckpt_take_o), 0);
    end
    retire_i = 1;
    nb();
    chk("R11", "no start in retire cycle", int'(ckpt_take_o), 0);
    retire_i = 0;
    nb();
    chk("R11", "start after retire", int'(ckpt_take_o), 1);
    quiet();
    nb();
    nb();

    // R9: commit-on-violate, buffer drains inside the window
    cov_en_i = 1;
    start_spec();
    violation_i = 1;
    nb();
    violation_i = 0;
    chk("R9", "snoop held", int'(snoop_hold_o), 1);
    chk("R9", "no abort", int'(flash_abort_o), 0);
    for (int i = 0; i < 4; i++) begin
      nb();
      chk("R9", "still held", int'(snoop_hold_o), 1);
    end
    sb_empty_i = 1;
    nb();
    chk("R9", "commit in window", int'(flash_commit_o), 1);
    chk("R9", "snoop released", int'(snoop_hold_o), 0);
    chk("R9", "no abort", int'(flash_abort_o), 0);
    quiet();
    nb();

    // R10: window expires; follows a partly used window, so length shows restart
    start_spec();
    violation_i = 1;
    nb();
    violation_i = 0;
    n = 0;
    while (snoop_hold_o && n < 100) begin
      n++;
      nb();
    end
    chk("R10", "hold length", n, WIN);
    chk("R10", "abort at expiry", int'(flash_abort_o), 1);
    chk("R10", "flush at expiry", int'(flush_o), 1);
    quiet();
    retire_i = 1;
    nb();
    retire_i = 0;
    nb();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule